// File: doc/BRIEF.md
# Multicore Fault Diagnosis Sequencer

This block steers the hardware-fault diagnosis flow of an NCORE-core system once a software-visible symptom has been raised. It issues phase commands to per-core replay engines. Each command names the cores that take part and, for each core, the core whose trace that core must replay. It waits for a single completion strobe that carries the aggregated results, and from the divergences reported it decides the next step. At the end it emits a verdict with a one-cycle valid pulse and, where a core is blamed, the index of that core.

The flow starts with a screening re-execution. If the symptom recurs, the sequencer records traces natively and then replays them rotated by one core. No divergence together with a recurring symptom means a deterministic software bug. No divergence and no symptom moves the flow on to the next instruction window, until the instruction budget is used up. Two adjacent divergences point at one core. A single divergence triggers a targeted replay on a third core to separate the replaying core from the trace producer. Any accusation must then be confirmed by the two cores that follow the accused one.

Top module: `fdiag_seq`

## Requirements
- R1: When idle (busy_o low), a symptom_i pulse is followed in the next cycle by a command with cmd_valid_o high, cmd_phase_o = 0 (screen), every core enabled and each core replaying its own trace. cmd_src_o holds core i's trace index in bits [i*IW +: IW].
- R2: If the screen completes with rep_symptom_i low, the verdict is 1 (transient or non-deterministic) and fault_core_o is 0.
- R3: If the screen completes with rep_symptom_i high, the next command is phase 1 (trace record) with every core on its own trace and cmd_start_o = 0.
- R4: After a trace record completes, the next command is phase 2 (replay) with every core enabled, and core i replays the trace of core (i-1) mod NCORE.
- R5: A rotated replay with no divergence and rep_symptom_i high gives verdict 2 (deterministic software bug).
- R6: A rotated replay with no divergence and no symptom advances cmd_start_o by WINDOW and returns to phase 1. In the window where cmd_start_o + WINDOW reaches BUDGET, it ends with verdict 4 (undiagnosed) instead.
- R7: Exactly two divergences at cores f and (f+1) mod NCORE make core f the accused core, and the flow goes to confirmation.
- R8: A single divergence at core d issues phase 2 with only core (d+1) mod NCORE enabled, replaying trace (d-1) mod NCORE. If that core diverges, the accused core is (d-1) mod NCORE; otherwise it is d.
- R9: Confirmation is phase 3, with exactly cores (f+1) and (f+2) mod NCORE enabled, each replaying trace f. Verdict 3 (faulty core, fault_core_o = f) is given only if both set rep_agree_i; otherwise the verdict is 4.
- R10: Three or more divergences, or two that are not adjacent, give verdict 4.
- R11: verdict_valid_o is high for exactly one cycle, and busy_o is low in the cycle after it. After reset the block is idle with verdict_o = 0.
- R12: A symptom_i pulse while busy_o is high has no effect on the command sequence.
- R13: No more than three replay or confirm commands complete within one instruction window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| symptom_i | input | 1 | Symptom pulse from the detectors |
| cmd_valid_o | output | 1 | A command is outstanding |
| cmd_phase_o | output | 2 | 0 screen, 1 trace record, 2 replay, 3 confirm |
| cmd_en_o | output | NCORE | Cores taking part in the command |
| cmd_src_o | output | NCORE*IW | Per-core trace index, core i at [i*IW +: IW] |
| cmd_start_o | output | SW | First instruction of the current window |
| rep_done_i | input | 1 | One-cycle completion strobe from the engines |
| rep_symptom_i | input | 1 | Symptom seen during the completed command |
| rep_div_i | input | NCORE | Per-core divergence of the completed command |
| rep_agree_i | input | NCORE | Per-core agreement with the accusation |
| busy_o | output | 1 | Diagnosis in progress |
| verdict_valid_o | output | 1 | One-cycle verdict strobe |
| verdict_o | output | 3 | 1 transient, 2 software bug, 3 faulty core, 4 undiagnosed |
| fault_core_o | output | IW | Accused core when verdict_o is 3 |

## Verification
The assertions take for granted that rep_done_i is a single-cycle strobe that arrives only while cmd_valid_o is high. They also assume that rep_symptom_i, rep_div_i and rep_agree_i are meaningful only in that cycle. The bench's responder keeps within this: it drives the strobe together with its results in exactly the cycle it first sees a command, and clears everything on the next cycle. Symptom pulses may arrive at any time, including during a diagnosis, because ignoring them is part of the behaviour under test.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

   typedef enum logic [1:0] {
      PH_SCREEN  = 2'd0,
      PH_TRACE   = 2'd1,
      PH_REPLAY  = 2'd2,
      PH_CONFIRM = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      VD_NONE      = 3'd0,
      VD_TRANSIENT = 3'd1,
      VD_SWBUG     = 3'd2,
      VD_FAULTY    = 3'd3,
      VD_UNDIAG    = 3'd4
   } verdict_e;

   typedef enum logic [1:0] {
      RT_SELF,
      RT_ROTATE,
      RT_TARGET,
      RT_CONFIRM
   } route_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SCREEN,
      S_TRACE,
      S_REP1,
      S_REP2,
      S_CONF,
      S_DONE
   } state_e;

endpackage

// File: rtl/fdiag_route.sv
module fdiag_route
   import fdiag_pkg::*;
#(
   parameter int NCORE = 3,
   parameter int IW    = 2
) (
   input  route_e                mode_i,
   input  logic [IW-1:0]         focus_i,
   output logic [NCORE-1:0]      en_o,
   output logic [NCORE*IW-1:0]   src_o
);

   function automatic logic [IW-1:0] inc_core(input logic [IW-1:0] x);
      return (x == IW'(NCORE-1)) ? '0 : x + 1'b1;
   endfunction

   function automatic logic [IW-1:0] dec_core(input logic [IW-1:0] x);
      return (x == '0) ? IW'(NCORE-1) : x - 1'b1;
   endfunction

   logic [IW-1:0] helper1, helper2, feeder;

   assign helper1 = inc_core(focus_i);
   assign helper2 = inc_core(helper1);
   assign feeder  = dec_core(focus_i);

   for (genvar i = 0; i < NCORE; i++) begin : g_core
      localparam int PREV = (i + NCORE - 1) % NCORE;
      logic          en_c;
      logic [IW-1:0] src_c;

      always_comb begin
         en_c  = 1'b0;
         src_c = IW'(i);
         unique case (mode_i)
            RT_SELF: begin
               en_c = 1'b1;
            end
            RT_ROTATE: begin
               en_c  = 1'b1;
               src_c = IW'(PREV);
            end
            RT_TARGET: begin
               en_c = (helper1 == IW'(i));
               if (en_c) src_c = feeder;
            end
            RT_CONFIRM: begin
               en_c = (helper1 == IW'(i)) || (helper2 == IW'(i));
               if (en_c) src_c = focus_i;
            end
            default: ;
         endcase
      end

      assign en_o[i]            = en_c;
      assign src_o[i*IW +: IW]  = src_c;
   end

endmodule

// File: rtl/fdiag_analyze.sv
module fdiag_analyze #(
   parameter int NCORE = 3,
   parameter int IW    = 2
) (
   input  logic [NCORE-1:0] div_i,
   output logic [1:0]       cnt_o,
   output logic [IW-1:0]    one_idx_o,
   output logic             pair_ok_o,
   output logic [IW-1:0]    pair_idx_o
);

   logic [NCORE-1:0] adj;

   for (genvar i = 0; i < NCORE; i++) begin : g_adj
      localparam int NXT = (i + 1) % NCORE;
      assign adj[i] = div_i[i] & div_i[NXT];
   end

   always_comb begin
      int total;
      total = 0;
      for (int i = 0; i < NCORE; i++) total += int'(div_i[i]);
      cnt_o = (total > 3) ? 2'd3 : 2'(total);
   end

   always_comb begin
      one_idx_o = '0;
      for (int i = NCORE - 1; i >= 0; i--) begin
         if (div_i[i]) one_idx_o = IW'(i);
      end
   end

   always_comb begin
      pair_idx_o = '0;
      for (int i = NCORE - 1; i >= 0; i--) begin
         if (adj[i]) pair_idx_o = IW'(i);
      end
      pair_ok_o = (cnt_o == 2'd2) && (|adj);
   end

endmodule

// File: rtl/fdiag_budget.sv
module fdiag_budget #(
   parameter int WINDOW = 100000,
   parameter int BUDGET = 20000000,
   parameter int SW     = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          advance_i,
   input  logic          rep_issue_i,
   output logic [SW-1:0] start_o,
   output logic          last_win_o
);

   localparam int LAST_START = ((BUDGET - 1) / WINDOW) * WINDOW;

   logic [SW-1:0] start_q;
   logic [2:0]    rep_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
      end else if (clear_i) begin
         start_q <= '0;
      end else if (advance_i) begin
         start_q <= start_q + SW'(WINDOW);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_cnt_q <= '0;
      end else if (clear_i || advance_i) begin
         rep_cnt_q <= '0;
      end else if (rep_issue_i) begin
         rep_cnt_q <= rep_cnt_q + 3'd1;
      end
   end

   assign start_o    = start_q;
   assign last_win_o = (start_q == SW'(LAST_START));

   AST_REPLAY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      rep_cnt_q <= 3'd3); // R13

   AST_START_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      advance_i |-> !last_win_o); // R6

endmodule

// File: rtl/fdiag_seq.sv
module fdiag_seq
   import fdiag_pkg::*;
#(
   parameter int NCORE  = 3,
   parameter int WINDOW = 100000,
   parameter int BUDGET = 20000000,
   localparam int IW    = (NCORE > 1) ? $clog2(NCORE) : 1,
   localparam int SW    = (BUDGET > 1) ? $clog2(BUDGET) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                symptom_i,
   output logic                cmd_valid_o,
   output logic [1:0]          cmd_phase_o,
   output logic [NCORE-1:0]    cmd_en_o,
   output logic [NCORE*IW-1:0] cmd_src_o,
   output logic [SW-1:0]       cmd_start_o,
   input  logic                rep_done_i,
   input  logic                rep_symptom_i,
   input  logic [NCORE-1:0]    rep_div_i,
   input  logic [NCORE-1:0]    rep_agree_i,
   output logic                busy_o,
   output logic                verdict_valid_o,
   output logic [2:0]          verdict_o,
   output logic [IW-1:0]       fault_core_o
);

   if (NCORE < 3) begin : g_bad_ncore
      $error("fdiag_seq: NCORE must be at least 3");
   end
   if (WINDOW < 1 || BUDGET < WINDOW) begin : g_bad_window
      $error("fdiag_seq: need 1 <= WINDOW <= BUDGET");
   end

   state_e        st_q, st_d;
   logic [IW-1:0] focus_q, focus_d;
   logic [2:0]    verd_q, verd_d;
   logic [IW-1:0] fault_q, fault_d;

   route_e            mode;
   phase_e            phase;
   logic [NCORE-1:0]  raw_en;
   logic              accept;
   logic [1:0]        div_cnt;
   logic [IW-1:0]     one_idx, pair_idx;
   logic              pair_ok;
   logic              last_win, advance, rep_issue, clear;

   function automatic logic [IW-1:0] dec_core(input logic [IW-1:0] x);
      return (x == '0) ? IW'(NCORE-1) : x - 1'b1;
   endfunction

   always_comb begin
      mode  = RT_SELF;
      phase = PH_SCREEN;
      unique case (st_q)
         S_TRACE: phase = PH_TRACE;
         S_REP1: begin
            mode  = RT_ROTATE;
            phase = PH_REPLAY;
         end
         S_REP2: begin
            mode  = RT_TARGET;
            phase = PH_REPLAY;
         end
         S_CONF: begin
            mode  = RT_CONFIRM;
            phase = PH_CONFIRM;
         end
         default: ;
      endcase
   end

   fdiag_route #(.NCORE(NCORE), .IW(IW)) u_route (
      .mode_i  (mode),
      .focus_i (focus_q),
      .en_o    (raw_en),
      .src_o   (cmd_src_o)
   );

   fdiag_analyze #(.NCORE(NCORE), .IW(IW)) u_analyze (
      .div_i      (rep_div_i),
      .cnt_o      (div_cnt),
      .one_idx_o  (one_idx),
      .pair_ok_o  (pair_ok),
      .pair_idx_o (pair_idx)
   );

   assign cmd_valid_o = (st_q == S_SCREEN) || (st_q == S_TRACE) ||
                        (st_q == S_REP1)   || (st_q == S_REP2)  || (st_q == S_CONF);
   assign cmd_phase_o = phase;
   assign cmd_en_o    = cmd_valid_o ? raw_en : '0;
   assign accept      = cmd_valid_o && rep_done_i;

   assign clear     = (st_q == S_IDLE) && symptom_i;
   assign advance   = accept && (st_q == S_REP1) && (div_cnt == 2'd0) &&
                      !rep_symptom_i && !last_win;
   assign rep_issue = accept && ((st_q == S_REP1) || (st_q == S_REP2) || (st_q == S_CONF));

   fdiag_budget #(.WINDOW(WINDOW), .BUDGET(BUDGET), .SW(SW)) u_budget (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear),
      .advance_i   (advance),
      .rep_issue_i (rep_issue),
      .start_o     (cmd_start_o),
      .last_win_o  (last_win)
   );

   always_comb begin
      st_d    = st_q;
      focus_d = focus_q;
      verd_d  = verd_q;
      fault_d = fault_q;
      unique case (st_q)
         S_IDLE: begin
            if (symptom_i) st_d = S_SCREEN;
         end
         S_SCREEN: begin
            if (rep_done_i) begin
               if (rep_symptom_i) begin
                  st_d = S_TRACE;
               end else begin
                  st_d    = S_DONE;
                  verd_d  = VD_TRANSIENT;
                  fault_d = '0;
               end
            end
         end
         S_TRACE: begin
            if (rep_done_i) st_d = S_REP1;
         end
         S_REP1: begin
            if (rep_done_i) begin
               unique case (div_cnt)
                  2'd0: begin
                     if (rep_symptom_i) begin
                        st_d    = S_DONE;
                        verd_d  = VD_SWBUG;
                        fault_d = '0;
                     end else if (last_win) begin
                        st_d    = S_DONE;
                        verd_d  = VD_UNDIAG;
                        fault_d = '0;
                     end else begin
                        st_d = S_TRACE;
                     end
                  end
                  2'd1: begin
                     focus_d = one_idx;
                     st_d    = S_REP2;
                  end
                  2'd2: begin
                     if (pair_ok) begin
                        focus_d = pair_idx;
                        st_d    = S_CONF;
                     end else begin
                        st_d    = S_DONE;
                        verd_d  = VD_UNDIAG;
                        fault_d = '0;
                     end
                  end
                  default: begin
                     st_d    = S_DONE;
                     verd_d  = VD_UNDIAG;
                     fault_d = '0;
                  end
               endcase
            end
         end
         S_REP2: begin
            if (rep_done_i) begin
               if (|(rep_div_i & cmd_en_o)) focus_d = dec_core(focus_q);
               st_d = S_CONF;
            end
         end
         S_CONF: begin
            if (rep_done_i) begin
               st_d = S_DONE;
               if ((rep_agree_i & cmd_en_o) == cmd_en_o) begin
                  verd_d  = VD_FAULTY;
                  fault_d = focus_q;
               end else begin
                  verd_d  = VD_UNDIAG;
                  fault_d = '0;
               end
            end
         end
         S_DONE: st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         focus_q <= '0;
         verd_q  <= VD_NONE;
         fault_q <= '0;
      end else begin
         st_q    <= st_d;
         focus_q <= focus_d;
         verd_q  <= verd_d;
         fault_q <= fault_d;
      end
   end

   assign busy_o          = (st_q != S_IDLE);
   assign verdict_valid_o = (st_q == S_DONE);
   assign verdict_o       = verd_q;
   assign fault_core_o    = fault_q;

   AST_SCREEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && symptom_i) |=> (cmd_valid_o && cmd_phase_o == PH_SCREEN && cmd_en_o == '1)); // R1

   AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid_o |=> (!verdict_valid_o && !busy_o)); // R11

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !verdict_valid_o) |=> busy_o); // R12

   AST_TARGET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_phase_o == PH_REPLAY && cmd_en_o != '1) |-> $countones(cmd_en_o) == 1); // R8

   AST_CONFIRM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_phase_o == PH_CONFIRM) |-> $countones(cmd_en_o) == 2); // R9

   AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_valid_o && verdict_o == VD_FAULTY) |-> (fault_core_o < IW'(NCORE))); // R9

   for (genvar i = 0; i < NCORE; i++) begin : g_rot_chk
      AST_ROTATE_NOSELF: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid_o && cmd_phase_o == PH_REPLAY && cmd_en_o == '1) |->
            (cmd_src_o[i*IW +: IW] != IW'(i))); // R4
   end

endmodule

// File: tb/fdiag_seq_bench.sv
`timescale 1ns/1ps
module fdiag_seq_bench;
   localparam int N   = 3;
   localparam int WIN = 100;
   localparam int BUD = 300;
   localparam int IW  = 2;
   localparam int SW  = 9;

   logic clk = 1'b0, rst_n = 1'b0, symptom = 1'b0;
   logic done = 1'b0, rsym = 1'b0;
   logic [N-1:0] rdiv = '0, ragree = '0;

   logic              cmd_valid_o, busy_o, verdict_valid_o;
   logic [1:0]        cmd_phase_o;
   logic [N-1:0]      cmd_en_o;
   logic [N*IW-1:0]   cmd_src_o;
   logic [SW-1:0]     cmd_start_o;
   logic [2:0]        verdict_o;
   logic [IW-1:0]     fault_core_o;

   fdiag_seq #(.NCORE(N), .WINDOW(WIN), .BUDGET(BUD)) u_fdiag_seq (
      .clk(clk), .rst_n(rst_n), .symptom_i(symptom),
      .cmd_valid_o(cmd_valid_o), .cmd_phase_o(cmd_phase_o), .cmd_en_o(cmd_en_o),
      .cmd_src_o(cmd_src_o), .cmd_start_o(cmd_start_o),
      .rep_done_i(done), .rep_symptom_i(rsym), .rep_div_i(rdiv), .rep_agree_i(ragree),
      .busy_o(busy_o), .verdict_valid_o(verdict_valid_o), .verdict_o(verdict_o),
      .fault_core_o(fault_core_o)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0, nrep = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference model: 0 idle,1 screen,2 trace,3 rotated replay,4 targeted replay,5 confirm,6 verdict
   int m_st = 0, m_focus = 0, m_start = 0, m_verd = 0, m_fault = 0;

   task fin(input int v);
      m_st = 6; m_verd = v; m_fault = (v == 3) ? m_focus : 0;
   endtask

   always @(posedge clk) begin
      int c, f;
      if (!rst_n) begin
         m_st = 0; m_focus = 0; m_start = 0; m_verd = 0; m_fault = 0;
      end else begin
         case (m_st)
            0: if (symptom) begin m_st = 1; m_start = 0; end
            1: if (done) begin if (rsym) m_st = 2; else fin(1); end
            2: if (done) m_st = 3;
            3: if (done) begin
                  c = 0;
                  for (int i = 0; i < N; i++) c += rdiv[i];
                  if (c == 0) begin
                     if (rsym) fin(2);
                     else if (m_start + WIN >= BUD) fin(4);
                     else begin m_start += WIN; m_st = 2; end
                  end else if (c == 1) begin
                     for (int i = 0; i < N; i++) if (rdiv[i]) m_focus = i;
                     m_st = 4;
                  end else if (c == 2) begin
                     f = -1;
                     for (int i = 0; i < N; i++) if (rdiv[i] && rdiv[(i+1)%N]) f = i;
                     if (f >= 0) begin m_focus = f; m_st = 5; end
                     else fin(4);
                  end else fin(4);
               end
            4: if (done) begin
                  if (rdiv[(m_focus+1)%N]) m_focus = (m_focus + N - 1) % N;
                  m_st = 5;
               end
            5: if (done) begin
                  if (ragree[(m_focus+1)%N] && ragree[(m_focus+2)%N]) fin(3);
                  else fin(4);
               end
            6: m_st = 0;
            default: m_st = 0;
         endcase
      end
   end

   function automatic string st_tag(input int s);
      case (s)
         1: return "R1 screen command";
         2: return "R3 trace command";
         3: return "R4 rotated replay command";
         4: return "R8 targeted replay command";
         5: return "R9 confirm command";
         6: return "R11 verdict cycle";
         default: return "R12 idle outputs";
      endcase
   endfunction

   always @(negedge clk) begin
      bit ev, ok;
      int eph;
      logic [N-1:0] een;
      logic [N*IW-1:0] esrc;
      ev  = (m_st >= 1 && m_st <= 5);
      eph = (m_st == 2) ? 1 : (m_st == 3 || m_st == 4) ? 2 : (m_st == 5) ? 3 : 0;
      een = '0;
      for (int i = 0; i < N; i++) esrc[i*IW +: IW] = IW'(i);
      case (m_st)
         1, 2: een = '1;
         3: begin
            een = '1;
            for (int i = 0; i < N; i++) esrc[i*IW +: IW] = IW'((i + N - 1) % N);
         end
         4: begin
            een[(m_focus+1)%N] = 1'b1;
            esrc[((m_focus+1)%N)*IW +: IW] = IW'((m_focus + N - 1) % N);
         end
         5: begin
            een[(m_focus+1)%N] = 1'b1;
            een[(m_focus+2)%N] = 1'b1;
            esrc[((m_focus+1)%N)*IW +: IW] = IW'(m_focus);
            esrc[((m_focus+2)%N)*IW +: IW] = IW'(m_focus);
         end
         default: ;
      endcase
      ok = (cmd_valid_o == ev) && (!ev || cmd_phase_o == eph) && (cmd_en_o == een) &&
           (cmd_src_o == esrc) && (cmd_start_o == m_start) && (busy_o == (m_st != 0)) &&
           (verdict_valid_o == (m_st == 6)) && (verdict_o == m_verd) && (fault_core_o == m_fault);
      chk(ok, st_tag(m_st), {busy_o, verdict_valid_o, verdict_o, cmd_en_o, cmd_phase_o},
          {(m_st != 0), (m_st == 6), 3'(m_verd), een, 2'(eph)});
   end

   task automatic pulse_sym();
      symptom = 1'b1;
      @(negedge clk);
      symptom = 1'b0;
   endtask

   task automatic resp(input logic s, input logic [N-1:0] d, input logic [N-1:0] a);
      int guard = 0;
      while (!cmd_valid_o && guard < 50) begin @(negedge clk); guard++; end
      if (cmd_phase_o == 2'd1) nrep = 0;
      else if (cmd_phase_o >= 2'd2) nrep++;
      done = 1'b1; rsym = s; rdiv = d; ragree = a;
      @(negedge clk);
      done = 1'b0; rsym = 1'b0; rdiv = '0; ragree = '0;
   endtask

   task automatic wait_v(input int v, input int f, input string tag);
      int guard = 0;
      while (!verdict_valid_o && guard < 50) begin @(negedge clk); guard++; end
      chk(verdict_valid_o && verdict_o == v && fault_core_o == f, tag, verdict_o, v);
      @(negedge clk);
      chk(!busy_o && !verdict_valid_o, "R11 idle after verdict", busy_o, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(!busy_o && !cmd_valid_o && verdict_o == 0, "R11 reset state", verdict_o, 0);
      @(negedge clk);

      // R1 / R2: screen clears the symptom
      pulse_sym();
      chk(cmd_valid_o && cmd_phase_o == 0 && cmd_en_o == 3'b111 && cmd_src_o == 6'b10_01_00,
          "R1 screen issued", cmd_phase_o, 0);
      resp(1'b0, '0, '0);
      wait_v(1, 0, "R2 transient verdict");

      // R3 / R4 / R5: deterministic software bug
      pulse_sym();
      resp(1'b1, '0, '0);
      chk(cmd_phase_o == 1 && cmd_start_o == 0 && cmd_src_o == 6'b10_01_00, "R3 trace record", cmd_phase_o, 1);
      resp(1'b0, '0, '0);
      chk(cmd_phase_o == 2 && cmd_src_o == 6'b01_00_10, "R4 rotated sources", cmd_src_o, 6'b01_00_10);
      resp(1'b1, '0, '0);
      wait_v(2, 0, "R5 software bug verdict");

      // R7 / R9 / R12: two adjacent divergences, symptom while busy
      pulse_sym();
      resp(1'b1, '0, '0);
      pulse_sym();
      chk(busy_o && cmd_phase_o == 1, "R12 symptom while busy ignored", cmd_phase_o, 1);
      resp(1'b0, '0, '0);
      resp(1'b0, 3'b110, '0);
      chk(cmd_phase_o == 3 && cmd_en_o == 3'b101, "R9 confirm cores", cmd_en_o, 3'b101);
      resp(1'b0, '0, 3'b101);
      wait_v(3, 1, "R7 paired divergence blames core 1");

      // R8 / R13: single divergence, helper blames the trace producer
      pulse_sym();
      resp(1'b1, '0, '0);
      resp(1'b0, '0, '0);
      resp(1'b0, 3'b001, '0);
      chk(cmd_phase_o == 2 && cmd_en_o == 3'b010 && cmd_src_o[3:2] == 2'd2, "R8 targeted replay", cmd_en_o, 3'b010);
      resp(1'b0, 3'b010, '0);
      chk(cmd_en_o == 3'b011, "R8 producer accused", cmd_en_o, 3'b011);
      resp(1'b0, '0, 3'b011);
      wait_v(3, 2, "R8 producer faulty verdict");
      chk(nrep == 3, "R13 replays in window", nrep, 3);

      // R9: confirmation with one dissenting core
      pulse_sym();
      resp(1'b1, '0, '0);
      resp(1'b0, '0, '0);
      resp(1'b0, 3'b100, '0);
      resp(1'b0, '0, '0);
      chk(cmd_phase_o == 3 && cmd_en_o == 3'b011, "R9 replaying core accused", cmd_en_o, 3'b011);
      resp(1'b0, '0, 3'b001);
      wait_v(4, 0, "R9 unconfirmed gives undiagnosed");

      // R6: budget runs out over three windows
      pulse_sym();
      resp(1'b1, '0, '0);
      for (int w = 0; w < 3; w++) begin
         chk(cmd_phase_o == 1 && cmd_start_o == w * WIN, "R6 window start", cmd_start_o, w * WIN);
         resp(1'b0, '0, '0);
         resp(1'b0, '0, '0);
      end
      wait_v(4, 0, "R6 budget exhausted");

      // R10: too many divergences
      pulse_sym();
      resp(1'b1, '0, '0);
      resp(1'b0, '0, '0);
      resp(1'b0, 3'b111, '0);
      wait_v(4, 0, "R10 three divergences");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule